// File: doc/BRIEF.md
# Serial Port Host Register Bank

This block is the byte-wide register file of a PC-style serial port as seen from a host bus. It has eight offsets. They hold:

- line control, modem control and scratch registers;
- a four-bit interrupt enable register;
- a 16-bit clock divisor, which is only stored and read back;
- views of line status, modem status and interrupt identification.

There is no bit shifting, baud generation or framing. A data write in normal mode leaves the block as a one-cycle byte strobe on the transmit side. Received bytes arrive on a valid/ready input stream and wait in a 64-entry queue until the host reads the data register.

Setting the loopback bit in modem control changes two things. Data writes go into the receive queue instead of the transmit strobe, and the external stream is consumed and discarded. The modem status view is also rebuilt from the modem control outputs.

A separate interrupt identification unit does three things:

- it records pending receive and transmit-empty causes;
- it drives a level interrupt output;
- it clears on an identification read.

Top module: `serial_host_regs`

## Requirements
- R1: Outside loopback and with divisor access off, a write to offset 0 raises `tx_valid` for exactly one cycle, one cycle after the write strobe, with `tx_data` equal to the written byte.
- R2: After reset, reads return line control 0x03, modem control 0x08, line status 0x60, modem status 0xB0, identification 0xC1, interrupt enable 0x00 and scratch 0x00. The divisor reads 0x000C.
- R3: A write to offset 1 (divisor access off) stores only bits 3:0 of the data; bits 7:4 read back as zero.
- R4: In loopback (modem control bit 4), a data write is queued as received data only while the queue holds fewer than 64 bytes, and is otherwise dropped. A loopback data write never raises `tx_valid`.
- R5: In loopback, a read of offset 6 returns bits 3:0 of the stored status (zero) with bit 5 = modem control bit 0, bit 4 = bit 1, bit 6 = bit 2 and bit 7 = bit 3. Outside loopback, offset 6 returns 0xB0.
- R6: A read of offset 0 (divisor access off) returns the oldest queued byte and removes it, or returns 0x00 when the queue is empty. Line status bit 0 is 1 exactly when the queue is non-empty.
- R7: Outside loopback, an input byte is accepted when `rx_in_valid` and `rx_in_ready` are both high. `rx_in_ready` is low while the queue holds 64 bytes. In loopback, `rx_in_ready` is high and input bytes are discarded.
- R8: When line control bit 7 is set, offsets 0 and 1 read and write the low and high divisor bytes. Such accesses neither pop the queue nor transmit.
- R9: The identification code holds bit 2 for a pending receive cause (set by a queue push while enable bit 0 is set) and bit 1 for a transmit-empty cause (set by a normal data write while enable bit 1 is set). Bit 0 is set when neither cause is pending. A read of offset 2 returns the code OR 0xC0 and resets the code to 0x01. A data read clears bit 2. `irq` is high exactly when bit 0 of the code is low.
- R10: Writes to offsets 2, 5 and 6 have no effect. `bus_rdata` changes only at the clock edge that samples `bus_rd`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmitted byte |
| rx_in_valid | input | 1 | External receive byte offered |
| rx_in_data | input | 8 | External receive byte |
| rx_in_ready | output | 1 | Receive byte accepted this cycle if valid |
| irq | output | 1 | Level interrupt, high while a cause is pending |

## Verification
Every bus result is due one clock edge after its strobe. This covers read data, the transmit strobe and the interrupt state. The bench raises each strobe at a falling edge and drops it at the next falling edge, so exactly one rising edge samples it. It reads `bus_rdata`, `tx_valid` and `irq` at that same falling edge, half a period after the register updates.

Queue effects of an accepted input byte become visible through a line status read issued after the byte is withdrawn. `rx_in_ready` depends only on the queue count and the mode, so it is sampled at falling edges before a byte is offered. The full, drop and discard cases are each followed by reads that empty the queue and compare order and contents.

// File: rtl/serial_regs_pkg.sv
// Shared offsets, reset values and bit positions of the serial host
// register bank. Assumes a 3-bit byte-wide register address space.
package serial_regs_pkg;
    localparam logic [2:0] OFF_DATA  = 3'd0;
    localparam logic [2:0] OFF_IEN   = 3'd1;
    localparam logic [2:0] OFF_IID   = 3'd2;
    localparam logic [2:0] OFF_LCTL  = 3'd3;
    localparam logic [2:0] OFF_MCTL  = 3'd4;
    localparam logic [2:0] OFF_LSTAT = 3'd5;
    localparam logic [2:0] OFF_MSTAT = 3'd6;
    localparam logic [2:0] OFF_SCR   = 3'd7;

    localparam logic [7:0]  LCTL_RST  = 8'h03;
    localparam logic [7:0]  MCTL_RST  = 8'h08;
    localparam logic [7:0]  MSTAT_RST = 8'hB0;
    localparam logic [15:0] DIV_RST   = 16'd12;

    localparam int LCTL_DIVSEL = 7;
    localparam int MCTL_LOOP   = 4;
endpackage

// File: rtl/serial_rx_queue.sv
// Circular receive byte queue. One push and one pop port; the caller must
// not push when full nor pop when empty. Head byte is shown combinationally.
module serial_rx_queue #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
    localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;

    assign full  = (count == CNT_MAX);
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    // Storage write on push; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/serial_irq_id.sv
// Interrupt identification unit. Holds receive (bit 2) and transmit-empty
// (bit 1) causes, bit 0 set when none is pending. Assumes the register
// bank qualifies the events; a set in the same cycle as a clear wins.
module serial_irq_id (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_event,
    input  logic       tx_event,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic       clr_all,
    input  logic       clr_rx,
    output logic [2:0] id,
    output logic       irq
);
    logic [2:0] id_nxt;

    // Next identification code from clears, then enabled sets.
    always_comb begin
        id_nxt = id;
        if (clr_all) id_nxt = 3'b001;
        if (clr_rx) begin
            id_nxt[2] = 1'b0;
            if (id_nxt[2:1] == 2'b00) id_nxt[0] = 1'b1;
        end
        if (rx_event && rx_en) begin
            id_nxt[2] = 1'b1;
            id_nxt[0] = 1'b0;
        end
        if (tx_event && tx_en) begin
            id_nxt[1] = 1'b1;
            id_nxt[0] = 1'b0;
        end
    end

    // Code register, reset to "nothing pending".
    always_ff @(posedge clk) begin
        if (!rst_n) id <= 3'b001;
        else        id <= id_nxt;
    end

    assign irq = ~id[0];
endmodule

// File: rtl/serial_host_regs.sv
// Serial port host register bank: eight byte offsets, divisor access via
// line control bit 7, loopback via modem control bit 4. Assumes one bus
// strobe (read or write) per cycle; read data is registered.
module serial_host_regs
    import serial_regs_pkg::*;
#(
    parameter int QDEPTH = 64,
    localparam int QCW = $clog2(QDEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       rx_in_valid,
    input  logic [7:0] rx_in_data,
    output logic       rx_in_ready,
    output logic       irq
);
    logic [7:0]     lcr_q, mcr_q, scr_q;
    logic [3:0]     ier_q;
    logic [15:0]    div_q;
    logic           divsel, loop_on;
    logic           wr_data, rd_data, rd_iid;
    logic           lb_push, ext_push, q_push, q_pop;
    logic [7:0]     q_din, q_head;
    logic [QCW-1:0] q_count;
    logic           q_full, q_empty;
    logic [2:0]     iid;
    logic [7:0]     msr_view, lsr_view, rd_val;

    assign divsel  = lcr_q[LCTL_DIVSEL];
    assign loop_on = mcr_q[MCTL_LOOP];
    assign wr_data = bus_wr && (bus_addr == OFF_DATA) && !divsel;
    assign rd_data = bus_rd && (bus_addr == OFF_DATA) && !divsel;
    assign rd_iid  = bus_rd && (bus_addr == OFF_IID);

    assign lb_push     = wr_data && loop_on && !q_full;
    assign ext_push    = rx_in_valid && !loop_on && !q_full;
    assign q_push      = lb_push || ext_push;
    assign q_din       = loop_on ? bus_wdata : rx_in_data;
    assign q_pop       = rd_data && !q_empty;
    assign rx_in_ready = loop_on || !q_full;

    serial_rx_queue #(.DEPTH(QDEPTH), .WIDTH(8)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (q_din),
        .pop   (q_pop),
        .head  (q_head),
        .count (q_count),
        .full  (q_full),
        .empty (q_empty)
    );

    serial_irq_id u_iid (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_event (q_push),
        .tx_event (wr_data && !loop_on),
        .rx_en    (ier_q[0]),
        .tx_en    (ier_q[1]),
        .clr_all  (rd_iid),
        .clr_rx   (rd_data),
        .id       (iid),
        .irq      (irq)
    );

    // Control register writes; status offsets ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q <= LCTL_RST;
            mcr_q <= MCTL_RST;
            scr_q <= 8'h00;
            ier_q <= 4'h0;
            div_q <= DIV_RST;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_DATA:  if (divsel) div_q[7:0]  <= bus_wdata;
                OFF_IEN:   if (divsel) div_q[15:8] <= bus_wdata;
                           else        ier_q       <= bus_wdata[3:0];
                OFF_LCTL:  lcr_q <= bus_wdata;
                OFF_MCTL:  mcr_q <= bus_wdata;
                OFF_SCR:   scr_q <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Transmit strobe one cycle after a normal-mode data write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= 8'h00;
        end else begin
            tx_valid <= wr_data && !loop_on;
            if (wr_data && !loop_on) tx_data <= bus_wdata;
        end
    end

    // Status views: modem lines rebuilt from control bits in loopback.
    assign msr_view = loop_on ? {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1], MSTAT_RST[3:0] & 4'h0}
                              : MSTAT_RST;
    assign lsr_view = {1'b0, 1'b1, 1'b1, 4'b0000, !q_empty};

    // Read multiplexer over offsets and divisor select.
    always_comb begin
        case (bus_addr)
            OFF_DATA:  rd_val = divsel ? div_q[7:0] : (q_empty ? 8'h00 : q_head);
            OFF_IEN:   rd_val = divsel ? div_q[15:8] : {4'h0, ier_q};
            OFF_IID:   rd_val = {2'b11, 3'b000, iid};
            OFF_LCTL:  rd_val = lcr_q;
            OFF_MCTL:  rd_val = mcr_q;
            OFF_LSTAT: rd_val = lsr_view;
            OFF_MSTAT: rd_val = msr_view;
            default:   rd_val = scr_q;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= 8'h00;
        else if (bus_rd) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/serial_host_regs_chk.sv
// Assertion checker for serial_host_regs, attached by bind below. Assumes
// access to the queue count, loopback bit and enable register of the top.
module serial_host_regs_chk #(
    parameter int QDEPTH = 64,
    parameter int QCW = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic [2:0]     bus_addr,
    input logic           tx_valid,
    input logic           rx_in_ready,
    input logic           irq,
    input logic [QCW-1:0] q_count,
    input logic           loop_on,
    input logic [3:0]     ier_q
);
    AST_TX_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_wr && bus_addr == 3'd0)); // R1

    AST_NO_LOOP_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(!loop_on)); // R4

    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= QDEPTH); // R4

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_on && int'(q_count) == QDEPTH) |-> !rx_in_ready); // R7

    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ier_q[1:0] != 2'b00)); // R9
endmodule

bind serial_host_regs serial_host_regs_chk #(.QDEPTH(QDEPTH), .QCW(QCW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .tx_valid    (tx_valid),
    .rx_in_ready (rx_in_ready),
    .irq         (irq),
    .q_count     (q_count),
    .loop_on     (loop_on),
    .ier_q       (ier_q)
);

// File: tb/serial_host_regs_bench.sv
// Bench for serial_host_regs: a vector table walked by one loop, then
// directed tests for transmit, receive queue, loopback and reset.
module serial_host_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       rx_in_valid = 1'b0;
    logic [7:0] rx_in_data = '0;
    logic       rx_in_ready;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_host_regs u_serial_host_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .rx_in_valid (rx_in_valid),
        .rx_in_data  (rx_in_data),
        .rx_in_ready (rx_in_ready),
        .irq         (irq)
    );

    typedef struct packed {
        logic       is_rd;
        logic [2:0] addr;
        logic [7:0] data;   // write data, or expected read data
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 26;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd3, 8'h03, 4'd2},   // R2 line control
        '{1'b1, 3'd4, 8'h08, 4'd2},   // R2 modem control
        '{1'b1, 3'd5, 8'h60, 4'd2},   // R2 line status
        '{1'b1, 3'd6, 8'hB0, 4'd2},   // R2 modem status
        '{1'b1, 3'd2, 8'hC1, 4'd2},   // R2 identification
        '{1'b1, 3'd1, 8'h00, 4'd2},   // R2 enable
        '{1'b1, 3'd7, 8'h00, 4'd2},   // R2 scratch
        '{1'b0, 3'd7, 8'hA5, 4'd0},
        '{1'b1, 3'd7, 8'hA5, 4'd10},  // R10 scratch round trip
        '{1'b0, 3'd3, 8'h80, 4'd0},
        '{1'b1, 3'd0, 8'h0C, 4'd2},   // R2 divisor low
        '{1'b1, 3'd1, 8'h00, 4'd2},   // R2 divisor high
        '{1'b0, 3'd0, 8'h34, 4'd0},
        '{1'b0, 3'd1, 8'h12, 4'd0},
        '{1'b1, 3'd0, 8'h34, 4'd8},   // R8
        '{1'b1, 3'd1, 8'h12, 4'd8},   // R8
        '{1'b0, 3'd3, 8'h03, 4'd0},
        '{1'b0, 3'd1, 8'hFF, 4'd0},
        '{1'b1, 3'd1, 8'h0F, 4'd3},   // R3
        '{1'b1, 3'd0, 8'h00, 4'd6},   // R6 empty read
        '{1'b0, 3'd5, 8'h00, 4'd0},
        '{1'b1, 3'd5, 8'h60, 4'd10},  // R10
        '{1'b0, 3'd6, 8'h00, 4'd0},
        '{1'b1, 3'd6, 8'hB0, 4'd10},  // R10
        '{1'b0, 3'd2, 8'h00, 4'd0},
        '{1'b1, 3'd2, 8'hC1, 4'd10}   // R10
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Each op starts at a falling edge and ends at the next one.
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic read_check(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        bus_read(a, d);
        check(d, exp, tag);
    endtask

    task automatic push_in(input logic [7:0] d);
        rx_in_valid = 1'b1; rx_in_data = d;
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        bit tx_seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check({7'h0, irq}, 8'h00, "R9 irq after reset");
        check({7'h0, rx_in_ready}, 8'h01, "R7 ready after reset");

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_rd) begin
                bus_read(VECS[i].addr, d);
                check(d, VECS[i].data, $sformatf("R%0d vector %0d", VECS[i].req, i));
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end

        // R1 transmit strobe and R9 transmit-empty cause (enable = 0x0F)
        bus_write(3'd0, 8'h41);
        check({7'h0, tx_valid}, 8'h01, "R1 tx_valid");
        check(tx_data, 8'h41, "R1 tx_data");
        check({7'h0, irq}, 8'h01, "R9 irq on tx");
        @(negedge clk);
        check({7'h0, tx_valid}, 8'h00, "R1 tx_valid one cycle");
        read_check(3'd2, 8'hC2, "R9 tx cause");
        read_check(3'd2, 8'hC1, "R9 cleared by read");
        check({7'h0, irq}, 8'h00, "R9 irq cleared");

        // R7 external input, R6 order and status, R9 receive cause
        push_in(8'h11);
        push_in(8'h22);
        read_check(3'd5, 8'h61, "R6 data ready");
        read_check(3'd2, 8'hC4, "R9 rx cause");
        bus_write(3'd1, 8'h01);
        read_check(3'd0, 8'h11, "R6 first byte");
        read_check(3'd2, 8'hC1, "R9 data read clears rx");
        read_check(3'd0, 8'h22, "R6 second byte");
        read_check(3'd5, 8'h60, "R6 empty status");
        read_check(3'd0, 8'h00, "R6 empty read");

        // R7 full queue stalls the input stream
        bus_write(3'd1, 8'h00);
        for (int i = 0; i < 64; i++) push_in(8'(i + 8'h80));
        check({7'h0, rx_in_ready}, 8'h00, "R7 stalled when full");
        push_in(8'hEE);
        push_in(8'hEE);
        read_check(3'd5, 8'h61, "R6 full status");
        for (int i = 0; i < 64; i++) read_check(3'd0, 8'(i + 8'h80), "R6 full drain order");
        read_check(3'd0, 8'h00, "R7 stalled byte not taken");

        // R5 loopback modem status
        bus_write(3'd4, 8'h1F);
        read_check(3'd6, 8'hF0, "R5 all lines");
        bus_write(3'd4, 8'h12);
        read_check(3'd6, 8'h10, "R5 RTS to CTS");
        bus_write(3'd4, 8'h19);
        read_check(3'd6, 8'hA0, "R5 DTR and OUT2");

        // R7 input ignored in loopback
        check({7'h0, rx_in_ready}, 8'h01, "R7 ready in loopback");
        push_in(8'h99);
        read_check(3'd5, 8'h60, "R7 loopback input discarded");

        // R4 loopback writes fill to 64 and drop the rest
        tx_seen = 1'b0;
        for (int i = 0; i < 65; i++) begin
            bus_write(3'd0, 8'(i));
            if (tx_valid) tx_seen = 1'b1;
        end
        check({7'h0, tx_seen}, 8'h00, "R4 no transmit in loopback");
        read_check(3'd5, 8'h61, "R4 loopback data queued");
        for (int i = 0; i < 64; i++) read_check(3'd0, 8'(i), "R4 loopback order");
        read_check(3'd0, 8'h00, "R4 65th byte dropped");

        // R8 divisor access does not touch queue or transmit
        bus_write(3'd4, 8'h08);
        push_in(8'h5A);
        bus_write(3'd3, 8'h83);
        bus_write(3'd0, 8'h77);
        check({7'h0, tx_valid}, 8'h00, "R8 divisor write no tx");
        read_check(3'd0, 8'h77, "R8 divisor low");
        bus_write(3'd3, 8'h03);
        read_check(3'd0, 8'h5A, "R8 queue untouched");

        // R2 reset restores defaults
        bus_write(3'd7, 8'h77);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_check(3'd7, 8'h00, "R2 scratch after reset");
        read_check(3'd3, 8'h03, "R2 line control after reset");
        bus_write(3'd3, 8'h83);
        read_check(3'd0, 8'h0C, "R2 divisor after reset");

        done = 1'b1;
        finish_run();
    end
endmodule